// File: doc/BRIEF.md
# Reference Clock Output Divider

This block derives a slower clock from the system clock. It divides by a power of two and shapes the high time to one of four fractions. The shaped clock always goes to an internal consumer, such as a modulator. It can also be placed on a shared output pin. The pin may be taken over by a fixed quarter-rate copy of the system clock. In crystal oscillator modes the pin is used as an oscillator input and is never driven.

Each period starts with its high phase. New divider and duty settings are loaded only when a period ends, so a change never produces a shortened pulse. While the sleep input is high, the system clock is treated as stopped at its low level. The counters freeze, and the outputs keep the value they had in the low half of the last awake cycle. A synchronous active-high reset stops the block. The block starts again on the first clock edge that samples the enable high. A slew-limit flag passes straight through to the pad control.

Top module: `refclk_div`

## Requirements
- R1: With the module enabled and divider code n (n from 2 to 7), ref_clk repeats every 2^n system clock cycles. Each period starts with its high phase on the first edge after the enable is sampled high, or on the first edge after the previous period ends.
- R2: For a divide ratio N of 4 or more, duty code 01 keeps ref_clk high for the first N/4 cycles of the period, code 10 for N/2 cycles and code 11 for 3N/4 cycles. Code 00 holds ref_clk low at every divider setting.
- R3: With divider code 0 and a non-zero duty code, ref_clk follows the system clock: high in the high half of each cycle and low in the low half.
- R4: With divider code 1 the period is two cycles. Code 10 is high for the whole first cycle. Code 01 is high only in the high half of the first cycle. Code 11 is high for the first cycle and for the high half of the second cycle.
- R5: While reset is high, at the next edge the block is stopped: ref_clk is low and the pin is not driven.
- R6: With the enable low, ref_clk stays low.
- R7: When CLKOUT is off and the oscillator is not in a crystal mode, the pin is driven with ref_clk only while the block runs and pin_oe is high. Otherwise pin_drive and pin_data are low.
- R8: When clkout_en is high and the oscillator is not in a crystal mode, the pin is driven with a system clock divided by 4 (two cycles high, two low), whatever the enable and pin_oe are.
- R9: With osc_xtal high, pin_drive and pin_data stay low, while ref_clk keeps running.
- R10: While sleep is high, the counters do not advance and ref_clk holds the value it had in the low half of the last awake cycle. After sleep ends, the sequence continues from where it stopped.
- R11: A change of div_sel or duty_sel in the middle of a period takes effect only from the next period boundary.
- R12: slew_lim_out always equals slew_lim_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Sleep: clock treated as stopped low, state frozen |
| en | input | 1 | Module enable |
| pin_oe | input | 1 | Request to place ref_clk on the pin |
| div_sel | input | 3 | Divider code n, ratio 2^n |
| duty_sel | input | 2 | Duty code: 00 off, 01 25%, 10 50%, 11 75% |
| slew_lim_in | input | 1 | Slew-limit request |
| clkout_en | input | 1 | Quarter-rate clock takes the pin |
| osc_xtal | input | 1 | Crystal oscillator mode, pin is an input |
| ref_clk | output | 1 | Reference clock to the internal consumer |
| pin_data | output | 1 | Value for the shared pin |
| pin_drive | output | 1 | Pin output driver enable |
| slew_lim_out | output | 1 | Slew-limit flag to the pad |

## Verification
A new setting can arrive while a period is still running. The collision is provoked by changing both selects in the low half of the second cycle of a divide-by-4 period. The bench then checks the tail of the old period and the first two periods of the new setting at half-cycle resolution. Sleep can also fall in the middle of a high phase. The bench raises sleep there and checks that ref_clk holds high and that the pattern resumes at the next count. A third test raises the CLKOUT and crystal-mode inputs while the divided clock is running. It confirms that the pin falls silent while ref_clk still runs.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  typedef enum logic [1:0] {
    DUTY_OFF  = 2'd0,
    DUTY_Q1   = 2'd1,
    DUTY_HALF = 2'd2,
    DUTY_Q3   = 2'd3
  } duty_e;

  typedef enum logic [1:0] {
    PIN_IDLE,
    PIN_QUARTER,
    PIN_REF
  } pin_src_e;
endpackage

// File: rtl/refclk_phase.sv
module refclk_phase #(
  parameter int DIV_W = 3,
  localparam int CNT_W = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep,
  input  logic             en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [1:0]       duty_sel,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic [DIV_W-1:0] div_a,
  output logic [1:0]       duty_a
);
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last;
  logic             wrap;

  assign span = {{CNT_W{1'b0}}, 1'b1} << div_a;
  assign last = CNT_W'(span - 1'b1);
  assign wrap = !run || (cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      cnt    <= '0;
      div_a  <= '0;
      duty_a <= '0;
    end else if (!sleep) begin
      if (!en) begin
        run    <= 1'b0;
        cnt    <= '0;
        div_a  <= div_sel;
        duty_a <= duty_sel;
      end else begin
        run <= 1'b1;
        if (wrap) begin
          cnt    <= '0;
          div_a  <= div_sel;
          duty_a <= duty_sel;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= last);
  p_sleep_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    (sleep && !rst) |=> $stable(cnt) && $stable(run));
  p_mid_period_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (run && en && !sleep && !rst && cnt != last) |=> $stable(div_a) && $stable(duty_a));
  p_reset_stop_r5: assert property (@(posedge clk)
    rst |=> !run && cnt == '0);
endmodule

// File: rtl/refclk_shape.sv
module refclk_shape
  import refclk_pkg::*;
#(
  parameter int DIV_W = 3,
  localparam int CNT_W = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_g,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [DIV_W-1:0] div_a,
  input  logic [1:0]       duty_a,
  output logic             ref_clk
);
  logic [CNT_W:0] thresh;
  logic           ph;
  duty_e          duty;

  assign duty   = duty_e'(duty_a);
  assign ph     = cnt[0];
  assign thresh = {{(CNT_W-1){1'b0}}, duty_a} << (div_a - DIV_W'(2));

  always_comb begin
    ref_clk = 1'b0;
    if (run && duty != DUTY_OFF) begin
      if (div_a == '0) begin
        ref_clk = clk_g;
      end else if (div_a == DIV_W'(1)) begin
        case (duty)
          DUTY_Q1:   ref_clk = !ph && clk_g;
          DUTY_HALF: ref_clk = !ph;
          default:   ref_clk = !ph || clk_g;
        endcase
      end else begin
        ref_clk = ({1'b0, cnt} < thresh);
      end
    end
  end

  p_duty_off_low_r2: assert property (@(posedge clk) disable iff (rst)
    (duty_a == 2'd0) |-> !ref_clk);
  p_period_starts_high_r1: assert property (@(posedge clk) disable iff (rst)
    (run && div_a >= DIV_W'(2) && cnt == '0 && duty_a != 2'd0) |-> ref_clk);
  p_stopped_low_r6: assert property (@(posedge clk) disable iff (rst)
    !run |-> !ref_clk);
endmodule

// File: rtl/refclk_pin.sv
module refclk_pin
  import refclk_pkg::*;
#(
  parameter int QDIV_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep,
  input  logic ref_clk,
  input  logic run,
  input  logic pin_oe,
  input  logic clkout_en,
  input  logic osc_xtal,
  output logic pin_data,
  output logic pin_drive
);
  logic [QDIV_W-1:0] qcnt;
  logic              quarter;
  pin_src_e          src;

  always_ff @(posedge clk) begin
    if (rst)         qcnt <= '0;
    else if (!sleep) qcnt <= qcnt + 1'b1;
  end

  assign quarter = !qcnt[QDIV_W-1];

  always_comb begin
    if (osc_xtal)          src = PIN_IDLE;
    else if (clkout_en)    src = PIN_QUARTER;
    else if (run && pin_oe) src = PIN_REF;
    else                   src = PIN_IDLE;
  end

  always_comb begin
    case (src)
      PIN_QUARTER: begin pin_drive = 1'b1; pin_data = quarter; end
      PIN_REF:     begin pin_drive = 1'b1; pin_data = ref_clk; end
      default:     begin pin_drive = 1'b0; pin_data = 1'b0;    end
    endcase
  end

  p_xtal_silent_r9: assert property (@(posedge clk) disable iff (rst)
    osc_xtal |-> !pin_drive && !pin_data);
  p_clkout_owns_pin_r8: assert property (@(posedge clk) disable iff (rst)
    (clkout_en && !osc_xtal) |-> pin_drive);
  p_quarter_turns_r8: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !rst && qcnt[0]) |=> $changed(qcnt[QDIV_W-1]));
  p_drive_needs_oe_r7: assert property (@(posedge clk) disable iff (rst)
    (!clkout_en && !pin_oe) |-> !pin_drive);
endmodule

// File: rtl/refclk_div.sv
module refclk_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep,
  input  logic             en,
  input  logic             pin_oe,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [1:0]       duty_sel,
  input  logic             slew_lim_in,
  input  logic             clkout_en,
  input  logic             osc_xtal,
  output logic             ref_clk,
  output logic             pin_data,
  output logic             pin_drive,
  output logic             slew_lim_out
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] div_a;
  logic [1:0]       duty_a;
  logic             clk_g;

  assign clk_g        = clk && !sleep;
  assign slew_lim_out = slew_lim_in;

  refclk_phase #(.DIV_W(DIV_W)) u_phase (
    .clk(clk), .rst(rst), .sleep(sleep), .en(en),
    .div_sel(div_sel), .duty_sel(duty_sel),
    .run(run), .cnt(cnt), .div_a(div_a), .duty_a(duty_a)
  );

  refclk_shape #(.DIV_W(DIV_W)) u_shape (
    .clk(clk), .rst(rst), .clk_g(clk_g), .run(run), .cnt(cnt),
    .div_a(div_a), .duty_a(duty_a), .ref_clk(ref_clk)
  );

  refclk_pin #(.QDIV_W(2)) u_pin (
    .clk(clk), .rst(rst), .sleep(sleep), .ref_clk(ref_clk), .run(run),
    .pin_oe(pin_oe), .clkout_en(clkout_en), .osc_xtal(osc_xtal),
    .pin_data(pin_data), .pin_drive(pin_drive)
  );

  p_slew_pass_r12: assert property (@(posedge clk) disable iff (rst)
    slew_lim_out == slew_lim_in);
endmodule

// File: tb/sim_refclk_div.sv
`timescale 1ns/100ps
module sim_refclk_div;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep = 1'b0, en = 1'b0, pin_oe = 1'b0, slew_lim_in = 1'b0;
  logic clkout_en = 1'b0, osc_xtal = 1'b0;
  logic [2:0] div_sel = '0;
  logic [1:0] duty_sel = '0;
  logic ref_clk, pin_data, pin_drive, slew_lim_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  refclk_div u0 (
    .clk(clk), .rst(rst), .sleep(sleep), .en(en), .pin_oe(pin_oe),
    .div_sel(div_sel), .duty_sel(duty_sel), .slew_lim_in(slew_lim_in),
    .clkout_en(clkout_en), .osc_xtal(osc_xtal), .ref_clk(ref_clk),
    .pin_data(pin_data), .pin_drive(pin_drive), .slew_lim_out(slew_lim_out)
  );

  localparam int NVEC = 12;
  // {div code, duty code}
  localparam logic [4:0] VEC [0:NVEC-1] = '{
    {3'd0, 2'd1}, {3'd0, 2'd3}, {3'd1, 2'd1}, {3'd1, 2'd2},
    {3'd1, 2'd3}, {3'd2, 2'd1}, {3'd2, 2'd3}, {3'd3, 2'd0},
    {3'd3, 2'd2}, {3'd5, 2'd3}, {3'd7, 2'd1}, {3'd4, 2'd2}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic at_hi(); @(posedge clk); #1; endtask
  task automatic at_lo(); @(negedge clk); #1; endtask

  // expected level at half-cycle h of a period (even h = high half)
  function automatic logic expv(input int dv, input int dt, input int h);
    int n;
    n = 1 << dv;
    if (dt == 0) return 1'b0;
    if (n == 1) return (h % 2) == 0;
    return (h % (2 * n)) < (dt * n / 2);
  endfunction

  function automatic string tag_of(input int dv, input int dt);
    if (dt == 0) return "R2";
    if (dv == 0) return "R3";
    if (dv == 1) return "R4";
    return "R1/R2";
  endfunction

  // restart with new settings; next posedge starts period at h=0
  task automatic restart(input int dv, input int dt);
    at_lo(); en = 1'b0;
    at_lo(); div_sel = 3'(dv); duty_sel = 2'(dt); en = 1'b1;
  endtask

  // mode 0: pin carries ref_clk, mode 1: pin silent
  task automatic run_pattern(input int dv, input int dt, input int mode);
    int n;
    n = 1 << dv;
    for (int k = 0; k < 2 * n; k++) begin
      at_hi();
      chk(tag_of(dv, dt), ref_clk, expv(dv, dt, 2 * k));
      if (mode == 0) chk("R7", pin_data, expv(dv, dt, 2 * k));
      else           chk("R9", pin_drive, 1'b0);
      at_lo();
      chk(tag_of(dv, dt), ref_clk, expv(dv, dt, 2 * k + 1));
    end
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic q [0:7];
    // R5: reset with everything requested
    en = 1'b1; pin_oe = 1'b1; div_sel = 3'd1; duty_sel = 2'd2;
    at_hi(); at_hi();
    chk("R5", ref_clk, 1'b0);
    chk("R5", pin_drive, 1'b0);
    at_lo();
    chk("R5", ref_clk, 1'b0);
    rst = 1'b0;
    at_hi(); // first edge with rst low: run starts, h=0
    chk("R5", ref_clk, 1'b1);

    // table of vectors, pin carrying ref_clk
    for (int i = 0; i < NVEC; i++) begin
      restart(int'(VEC[i][4:2]), int'(VEC[i][1:0]));
      run_pattern(int'(VEC[i][4:2]), int'(VEC[i][1:0]), 0);
    end

    // R6: disabled
    at_lo(); en = 1'b0; duty_sel = 2'd3;
    for (int k = 0; k < 4; k++) begin
      at_hi(); chk("R6", ref_clk, 1'b0);
      at_lo(); chk("R6", ref_clk, 1'b0);
    end
    chk("R7", pin_drive, 1'b0);

    // R7: running but pin_oe low
    restart(2, 2); pin_oe = 1'b0;
    at_hi(); chk("R7", ref_clk, 1'b1);
    chk("R7", pin_drive, 1'b0); chk("R7", pin_data, 1'b0);
    pin_oe = 1'b1;

    // R8: quarter-rate clock owns the pin, even when disabled
    at_lo(); clkout_en = 1'b1; en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      at_hi(); q[k] = pin_data; chk("R8", pin_drive, 1'b1);
    end
    for (int k = 4; k < 8; k++) begin
      chk("R8", q[k], q[k-4]);
      chk("R8", q[k], !q[k-2]);
    end

    // R9: crystal mode silences pin, ref keeps running
    osc_xtal = 1'b1;
    restart(1, 2);
    run_pattern(1, 2, 1);
    restart(3, 1);
    run_pattern(3, 1, 1);
    chk("R9", pin_data, 1'b0);
    osc_xtal = 1'b0; clkout_en = 1'b0;

    // R10: sleep inside high phase of divide-by-4, 50%
    restart(2, 2);
    at_hi(); chk("R10", ref_clk, 1'b1); // cnt 0
    at_hi(); chk("R10", ref_clk, 1'b1); // cnt 1
    at_lo(); sleep = 1'b1;
    for (int k = 0; k < 5; k++) begin
      at_hi(); chk("R10", ref_clk, 1'b1);
      at_lo(); chk("R10", ref_clk, 1'b1);
    end
    sleep = 1'b0;
    at_hi(); chk("R10", ref_clk, 1'b0); // cnt 2
    at_hi(); chk("R10", ref_clk, 1'b0); // cnt 3
    at_hi(); chk("R10", ref_clk, 1'b1); // cnt 0
    // R10: sleep with divide-by-1 holds the low-half value
    restart(0, 2);
    at_hi(); chk("R10", ref_clk, 1'b1);
    at_lo(); sleep = 1'b1;
    at_hi(); chk("R10", ref_clk, 1'b0);
    at_hi(); chk("R10", ref_clk, 1'b0);
    at_lo(); sleep = 1'b0;
    at_hi(); chk("R10", ref_clk, 1'b1);

    // R11: change settings mid period (divide-by-4 25% -> divide-by-2 50%)
    restart(2, 1);
    at_hi(); chk("R11", ref_clk, 1'b1); // cnt 0
    at_hi(); chk("R11", ref_clk, 1'b0); // cnt 1
    at_lo(); div_sel = 3'd1; duty_sel = 2'd2;
    at_hi(); chk("R11", ref_clk, 1'b0); // cnt 2, old setting
    at_hi(); chk("R11", ref_clk, 1'b0); // cnt 3, old setting
    at_hi(); chk("R11", ref_clk, 1'b1); // new period
    at_lo(); chk("R11", ref_clk, 1'b1);
    at_hi(); chk("R11", ref_clk, 1'b0);
    at_hi(); chk("R11", ref_clk, 1'b1);

    // R12: slew flag pass-through
    slew_lim_in = 1'b1; #1; chk("R12", slew_lim_out, 1'b1);
    slew_lim_in = 1'b0; #1; chk("R12", slew_lim_out, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule